// File: doc/BRIEF.md
# Write-Side Block Access Entry Decoder

This block sits on the write-control pins of a serial field memory and decides, clock by clock, whether a reset-write is an ordinary pointer reset or the start of a jump to a random write block. Every rising edge of the reset-write line is a standard reset. The reset edge counts as clock 0 of a sequence. During clocks 1 to 4 after it, the block watches for a fixed handshake on write enable and input enable. If the handshake matches, the block reads a block address serially from a control pin, MSB first. It then counts out the write latency and announces the new block with a one-cycle load strobe.

At clock 5 the level of write enable selects the address pin: the data bit 0 line or the input enable line. The address is checked against the legal block range. An illegal address raises a sticky error instead of a load. A fresh reset-write edge at any point abandons the sequence and restarts the count.

Top module: `blk_entry_dec`

## Requirements
- R1: The sampling edge at which `rstw` is high after being low at the previous edge is clock 0. After that edge, `ptr_rst` is high for exactly one cycle, and `blk_mode`, `lat_busy` and `addr_err` are 0.
- R2: Block entry continues only if clocks 1 and 2 see `we`=1, `ie`=0 and clocks 3 and 4 see `we`=0, `ie`=1. On any mismatch the block returns to standard mode: no latency, no load and no error follow.
- R3: At clock 5, `we`=0 selects `d0` as the address pin and `we`=1 selects `ie`. Address bit 12 (the MSB) is sampled from the selected pin on that clock.
- R4: Address bits 11 down to 0 are sampled from the selected pin on clocks 6 to 17, so bit 0 (the LSB) is taken at clock 17.
- R5: For a legal address, `lat_busy` is high after clocks 17 to 34 (18 cycles) and low after clock 35.
- R6: After clock 35, `load_stb` is high for exactly one cycle. In that cycle `blk_addr` equals the assembled address and `blk_mode` is 1.
- R7: An address above 6143 sets `addr_err` after clock 17. It produces no latency and no load. `addr_err` stays set until the next reset-write edge clears it.
- R8: A reset-write edge in the middle of a sequence cancels it: no load follows, and the count restarts from clock 0.
- R9: `blk_mode` and `blk_addr` keep their values between loads. A reset-write edge clears `blk_mode` and leaves `blk_addr` unchanged.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rstw | input | 1 | Reset-write line; a rising level starts a sequence |
| we | input | 1 | Write enable |
| ie | input | 1 | Input enable; may carry the serial address |
| d0 | input | 1 | Data bit 0; may carry the serial address |
| ptr_rst | output | 1 | One-cycle standard pointer reset pulse |
| blk_mode | output | 1 | Random write block mode active |
| lat_busy | output | 1 | Write latency period in progress |
| load_stb | output | 1 | One-cycle strobe marking a new block address |
| blk_addr | output | 13 | Block address of the most recent load |
| addr_err | output | 1 | Sticky flag for an out-of-range block address |

## Verification
A sequence counter that is off by one shifts the `lat_busy` window and the `load_stb` by a cycle, and the per-edge comparison catches this at once. A wrong pin choice or wrong bit order shows as a wrong `blk_addr` in the load cycle, 18 cycles after the last address bit. A bad handshake decode or a wrong range limit shows within one edge of clock 17: either a latency window that should not exist or a missing `addr_err`.

// File: rtl/blkacc_pkg.sv
package blkacc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PAT,
    ST_ADDR,
    ST_LAT
  } seq_st_e;

  // handshake check: first half of the pattern wants we high / ie low,
  // second half wants we low / ie high
  function automatic logic pat_ok(input int unsigned idx,
                                  input int unsigned half,
                                  input logic we_i,
                                  input logic ie_i);
    if (idx <= half) return we_i && !ie_i;
    return !we_i && ie_i;
  endfunction

  function automatic logic addr_legal(input logic [31:0] a,
                                      input int unsigned lim);
    return a <= lim;
  endfunction

endpackage

// File: rtl/rstw_rise_det.sv
module rstw_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic rstw,
  output logic rise
);
  logic rstw_q;

  // reset to 1 so a line held high through reset gives no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rstw_q <= 1'b1;
    else        rstw_q <= rstw;
  end

  assign rise = rstw && !rstw_q;

endmodule

// File: rtl/blk_addr_shift.sv
module blk_addr_shift #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [ADDR_W-1:0] sh_q,
  output logic [ADDR_W-1:0] sh_next
);
  assign sh_next = {sh_q[ADDR_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (clr)      sh_q <= '0;
    else if (shift_en) sh_q <= sh_next;
  end

endmodule

// File: rtl/blk_seq_fsm.sv
module blk_seq_fsm
  import blkacc_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int PAT_LEN = 4,
  parameter int LAT_CYC = 18,
  parameter int MAX_BLK = 6143
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              we,
  input  logic              ie,
  input  logic              d0,
  input  logic [ADDR_W-1:0] sh_q,
  input  logic [ADDR_W-1:0] sh_next,
  output logic              shift_en,
  output logic              bit_in,
  output logic              ptr_rst,
  output logic              blk_mode,
  output logic              lat_busy,
  output logic              load_stb,
  output logic [ADDR_W-1:0] blk_addr,
  output logic              addr_err
);
  localparam int FIRST_ADDR = PAT_LEN + 1;
  localparam int LAST_ADDR  = PAT_LEN + ADDR_W;
  localparam int LAST_LAT   = LAST_ADDR + LAT_CYC;
  localparam int CNT_W      = $clog2(LAST_LAT + 1);
  localparam int HALF       = PAT_LEN / 2;

  seq_st_e    state;
  logic [CNT_W-1:0] cnt;    // number of the edge about to be processed
  logic       sel_ie;
  logic       at_first;

  assign at_first = (cnt == CNT_W'(FIRST_ADDR));
  assign shift_en = (state == ST_ADDR) && !rise;
  assign bit_in   = at_first ? (we ? ie : d0) : (sel_ie ? ie : d0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sel_ie   <= 1'b0;
      ptr_rst  <= 1'b0;
      blk_mode <= 1'b0;
      lat_busy <= 1'b0;
      load_stb <= 1'b0;
      blk_addr <= '0;
      addr_err <= 1'b0;
    end else begin
      ptr_rst  <= 1'b0;
      load_stb <= 1'b0;
      if (rise) begin
        state    <= ST_PAT;
        cnt      <= CNT_W'(1);
        sel_ie   <= 1'b0;
        ptr_rst  <= 1'b1;
        blk_mode <= 1'b0;
        lat_busy <= 1'b0;
        addr_err <= 1'b0;
      end else begin
        case (state)
          ST_PAT: begin
            if (pat_ok(int'(cnt), HALF, we, ie)) begin
              if (cnt == CNT_W'(PAT_LEN)) state <= ST_ADDR;
              cnt <= cnt + 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_ADDR: begin
            if (at_first) sel_ie <= we;
            if (cnt == CNT_W'(LAST_ADDR)) begin
              if (addr_legal(32'(sh_next), MAX_BLK)) begin
                state    <= ST_LAT;
                lat_busy <= 1'b1;
              end else begin
                state    <= ST_IDLE;
                addr_err <= 1'b1;
              end
            end
            cnt <= cnt + 1'b1;
          end
          ST_LAT: begin
            if (cnt == CNT_W'(LAST_LAT)) begin
              lat_busy <= 1'b0;
              load_stb <= 1'b1;
              blk_mode <= 1'b1;
              blk_addr <= sh_q;
              state    <= ST_IDLE;
            end
            cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_rst_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |-> (!blk_mode && !lat_busy && !addr_err && !load_stb));

  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lat_busy) |-> (load_stb || ptr_rst));

  assert_load_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  assert_load_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> (blk_mode && !lat_busy));

  assert_load_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> (32'(blk_addr) <= MAX_BLK));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> (addr_err || ptr_rst));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb |=> $stable(blk_addr) || load_stb);

endmodule

// File: rtl/blk_entry_dec.sv
module blk_entry_dec #(
  parameter int ADDR_W  = 13,
  parameter int PAT_LEN = 4,
  parameter int LAT_CYC = 18,
  parameter int MAX_BLK = 6143
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rstw,
  input  logic              we,
  input  logic              ie,
  input  logic              d0,
  output logic              ptr_rst,
  output logic              blk_mode,
  output logic              lat_busy,
  output logic              load_stb,
  output logic [ADDR_W-1:0] blk_addr,
  output logic              addr_err
);
  logic              rise;
  logic              shift_en;
  logic              bit_in;
  logic [ADDR_W-1:0] sh_q;
  logic [ADDR_W-1:0] sh_next;

  rstw_rise_det u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .rstw  (rstw),
    .rise  (rise)
  );

  blk_addr_shift #(.ADDR_W(ADDR_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rise),
    .shift_en (shift_en),
    .bit_in   (bit_in),
    .sh_q     (sh_q),
    .sh_next  (sh_next)
  );

  blk_seq_fsm #(
    .ADDR_W  (ADDR_W),
    .PAT_LEN (PAT_LEN),
    .LAT_CYC (LAT_CYC),
    .MAX_BLK (MAX_BLK)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .we       (we),
    .ie       (ie),
    .d0       (d0),
    .sh_q     (sh_q),
    .sh_next  (sh_next),
    .shift_en (shift_en),
    .bit_in   (bit_in),
    .ptr_rst  (ptr_rst),
    .blk_mode (blk_mode),
    .lat_busy (lat_busy),
    .load_stb (load_stb),
    .blk_addr (blk_addr),
    .addr_err (addr_err)
  );

endmodule

// File: tb/test_blk_entry_dec.sv
`timescale 1ns/1ps
module test_blk_entry_dec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rstw = 1'b0, we = 1'b0, ie = 1'b0, d0 = 1'b0;
  logic ptr_rst, blk_mode, lat_busy, load_stb, addr_err;
  logic [12:0] blk_addr;

  int checks = 0;
  int fails = 0;
  logic [12:0] exp_q[$];
  logic [12:0] last_addr = '0;

  always #2.5 clk = ~clk;

  blk_entry_dec i_blk_entry_dec (
    .clk(clk), .rst_n(rst_n), .rstw(rstw), .we(we), .ie(ie), .d0(d0),
    .ptr_rst(ptr_rst), .blk_mode(blk_mode), .lat_busy(lat_busy),
    .load_stb(load_stb), .blk_addr(blk_addr), .addr_err(addr_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops the scoreboard on each load strobe (R6)
  always @(negedge clk) begin
    if (rst_n && load_stb) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected load", int'(blk_addr), -1);
      end else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        chk(blk_addr == e, "R6 load address", int'(blk_addr), int'(e));
        chk(blk_mode == 1'b1, "R6 mode at load", int'(blk_mode), 1);
      end
    end
  end

  task automatic drive(input logic r, input logic w, input logic i, input logic d);
    @(negedge clk);
    rstw = r; we = w; ie = i; d0 = d;
    @(posedge clk);
    #1;
  endtask

  // driver: one full sequence; edge 0 is the reset-write edge
  task automatic entry(input bit sel, input logic [12:0] a, input bit bad, input int cancel_at);
    bit legal, ok, perr, live;
    logic r, w, i, d;
    legal = (a <= 13'd6143);
    ok    = legal && !bad && (cancel_at == 0);
    perr  = !legal && !bad && (cancel_at == 0);
    if (ok) exp_q.push_back(a);
    for (int k = 0; k <= 36; k++) begin
      r = (k == 0) || (cancel_at != 0 && k == cancel_at);
      w = 1'b0; i = 1'b0; d = 1'b0;
      if (k == 1 || k == 2) begin w = 1'b1; i = bad; end
      if (k == 3 || k == 4) i = 1'b1;
      if (k == 5) begin w = sel; if (sel) i = a[12]; else d = a[12]; end
      if (k >= 6 && k <= 17) begin
        if (sel) i = a[17-k]; else d = a[17-k];
      end
      drive(r, w, i, d);
      live = (cancel_at == 0) || (k < cancel_at);
      if (r) begin
        chk(ptr_rst == 1'b1, "R1 ptr_rst pulse", int'(ptr_rst), 1);
        chk(!blk_mode && !lat_busy && !addr_err, "R1 cleared flags",
            int'({blk_mode, lat_busy, addr_err}), 0);
        chk(blk_addr == last_addr, "R9 address kept over reset", int'(blk_addr), int'(last_addr));
      end else begin
        chk(ptr_rst == 1'b0, "R1 single pulse", int'(ptr_rst), 0);
        chk(lat_busy == (ok && k >= 17 && k <= 34), "R5 latency window",
            int'(lat_busy), int'(ok && k >= 17 && k <= 34));
        if (k >= 17)
          chk(addr_err == perr, "R7 error flag", int'(addr_err), int'(perr));
        if (k == 35)
          chk(load_stb == ok, "R6/R8 load timing", int'(load_stb), int'(ok));
        if (k == 36)
          chk(load_stb == 1'b0, "R6 single load", int'(load_stb), 0);
        if (!live && k > 35)
          chk(exp_q.size() == 0, "R8 cancelled no load", exp_q.size(), 0);
      end
    end
    if (ok) last_addr = a;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    // R10: reset state
    chk({ptr_rst, blk_mode, lat_busy, load_stb, addr_err} == 5'b0, "R10 flags in reset",
        int'({ptr_rst, blk_mode, lat_busy, load_stb, addr_err}), 0);
    chk(blk_addr == 13'd0, "R10 address in reset", int'(blk_addr), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk(blk_mode == 1'b0 && ptr_rst == 1'b0, "R10 idle after reset", int'(blk_mode), 0);

    entry(1'b0, 13'h0ABC, 1'b0, 0);   // R3 R4 d0 pin
    idle(5);
    chk(blk_mode == 1'b1, "R9 mode held", int'(blk_mode), 1);
    chk(blk_addr == 13'h0ABC, "R9 address held", int'(blk_addr), 'h0ABC);
    entry(1'b1, 13'd6143, 1'b0, 0);   // R3 R4 ie pin, top legal value
    entry(1'b0, 13'd0, 1'b0, 0);      // lowest address
    entry(1'b0, 13'd6144, 1'b0, 0);   // R7 illegal
    idle(20);
    chk(addr_err == 1'b1, "R7 error sticky", int'(addr_err), 1);
    entry(1'b1, 13'h1FFF, 1'b0, 0);   // R7 illegal via ie pin
    entry(1'b1, 13'h0555, 1'b1, 0);   // R2 bad handshake
    entry(1'b0, 13'h0123, 1'b0, 10);  // R8 cancel mid address
    entry(1'b1, 13'h1234, 1'b0, 0);   // recovery after cancel
    idle(4);
    chk(exp_q.size() == 0, "R6 all loads seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule